// File: doc/BRIEF.md
# Masked SM4 Substitution Box, Three-Stage Pipeline

This block computes the SM4 byte substitution on data that never appears in the clear. The operand arrives as three Boolean shares whose XOR is the true byte. The result leaves as three shares whose XOR is the substituted byte. Each new operand also takes 8 fresh random bits. The block accepts one operand per clock and has a fixed pipeline delay. It is intended to sit inside a masked cipher round, which supplies the shares and the random bits.

Internally the substitution is written as an affine map, then inversion in GF(2^8), then a second affine map. The inversion uses a tower of GF(2^4) over GF(2), which gives three register-separated stages:
- **Stage one** maps each share into the tower basis. It computes the shared norm term, which is a 3-share GF(2^4) product plus the linear square-and-scale part. It then spreads the norm term into five shares using the 8 random bits.
- **Stage two** inverts the norm in GF(2^4) on five shares.
- **Stage three** multiplies the 5-share inverse by the 3-share upper and lower halves. It then maps each share back through the output basis change and affine map.

Each output share is computed without at least one input share of every operand it depends on.

Top module: `sm4ti_sbox`

## Requirements
- R1: When an operand is accepted, the XOR of the three output shares equals the SM4 substitution of the XOR of the three input shares.
- R2: An operand is accepted on a rising edge where `in_vld` is 1. Its result is on the outputs just after the second rising edge that follows, and `out_vld` is 1 for exactly that one cycle. When `in_vld` is 0, `out_vld` is 0 three edges later.
- R3: The recombined result does not depend on how the operand is split into shares. The same byte split in different ways gives the same recombined output.
- R4: The recombined result does not depend on the value of `rnd`.
- R5: Operands presented on consecutive cycles are each processed: one result per cycle, in order.
- R6: On an edge where `in_vld` is 0, the input shares and `rnd` are ignored. The output shares keep the values they had before.
- R7: While `rst_n` is 0 and just after it is released, `out_vld` is 0 and all output shares are 0.
- R8: A zero operand is handled with inversion of zero defined as zero. In particular, S(0x00)=0xD6. The known values S(0x01)=0x90 and S(0xFF)=0x48 also hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand present this cycle |
| in_sh0 | input | 8 | Input share 0 |
| in_sh1 | input | 8 | Input share 1 |
| in_sh2 | input | 8 | Input share 2 |
| rnd | input | 8 | Fresh random bits for this operand |
| out_vld | output | 1 | Result shares are new this cycle |
| out_sh0 | output | 8 | Output share 0 |
| out_sh1 | output | 8 | Output share 1 |
| out_sh2 | output | 8 | Output share 2 |

## Verification
All 256 byte values are run back to back with random share splits and random masks. This separates a wrong basis change, affine constant or tower formula from a correct one, and it also shows one-per-cycle throughput.

Three directed sequences target specific faults:
- One byte is sent repeatedly under different splits with fixed random bits. This exposes cross terms that are dropped or duplicated between shares.
- One fixed split is sent repeatedly under different random bits. This exposes unbalanced remasking.
- Random gaps with garbage on idle inputs check that invalid cycles leave the output shares untouched.

Zero, one and 0xFF are sent with the pipeline timing checked on every cycle.

// File: rtl/sm4ti_pkg.sv
package sm4ti_pkg;

  localparam int unsigned BW      = 8;   // byte width
  localparam int unsigned HW      = 4;   // subfield width
  localparam int unsigned NS_IN   = 3;   // shares on ports and in stage 3 halves
  localparam int unsigned NS_INV  = 5;   // shares around the subfield inverter
  localparam int unsigned RND_W   = 2 * HW;

  localparam logic [HW-1:0] LAMBDA  = 4'h8;   // y^2 = y + LAMBDA, trace one
  localparam logic [BW-1:0] AFF_C   = 8'hD3;
  localparam logic [BW:0]   POLY8   = 9'h1F5;
  // row i (bit i of result) in [8i +: 8]
  localparam logic [8*BW-1:0] AFF_ROWS =
    {8'hD3, 8'hE9, 8'hF4, 8'h7A, 8'h3D, 8'h9E, 8'h4F, 8'hA7};

  // GF(2^4), modulus x^4 + x + 1
  function automatic logic [HW-1:0] gf16_mul(input logic [HW-1:0] a, input logic [HW-1:0] b);
    logic [HW-1:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < HW; i++) begin
      if (b[i]) acc ^= sh;
      sh = {sh[HW-2:0], 1'b0} ^ (sh[HW-1] ? 4'h3 : 4'h0);
    end
    return acc;
  endfunction

  function automatic logic [HW-1:0] sq_scale(input logic [HW-1:0] h, input logic [HW-1:0] l);
    return gf16_mul(gf16_mul(h, h), LAMBDA) ^ gf16_mul(l, l);
  endfunction

  // x^14 by repeated multiplication; used only as a check reference
  function automatic logic [HW-1:0] gf16_inv_ref(input logic [HW-1:0] x);
    logic [HW-1:0] r;
    r = 4'h1;
    for (int i = 0; i < 14; i++) r = gf16_mul(r, x);
    return r;
  endfunction

  // tower element {hi, lo} = hi*y + lo
  function automatic logic [BW-1:0] t_mul(input logic [BW-1:0] a, input logic [BW-1:0] b);
    logic [HW-1:0] hh;
    hh = gf16_mul(a[7:4], b[7:4]);
    return {hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]),
            gf16_mul(hh, LAMBDA) ^ gf16_mul(a[3:0], b[3:0])};
  endfunction

  function automatic logic [BW-1:0] aff_lin(input logic [BW-1:0] x);
    logic [BW-1:0] y;
    for (int i = 0; i < BW; i++) y[i] = ^(AFF_ROWS[8*i +: 8] & x);
    return y;
  endfunction

  // column j of a matrix in [8j +: 8]
  function automatic logic [BW-1:0] mat_apply(input logic [8*BW-1:0] m, input logic [BW-1:0] x);
    logic [BW-1:0] y;
    y = '0;
    for (int j = 0; j < BW; j++) if (x[j]) y ^= m[8*j +: 8];
    return y;
  endfunction

  function automatic logic [BW-1:0] find_root();
    logic [BW-1:0] root, acc, pw;
    logic          found;
    root  = '0;
    found = 1'b0;
    for (int c = 2; c < 256; c++) begin
      acc = '0;
      pw  = 8'h01;
      for (int i = 0; i <= BW; i++) begin
        if (POLY8[i]) acc ^= pw;
        pw = t_mul(pw, 8'(c));
      end
      if (!found && acc == 8'h00) begin
        root  = 8'(c);
        found = 1'b1;
      end
    end
    return root;
  endfunction

  function automatic logic [8*BW-1:0] map_fwd();
    logic [8*BW-1:0] m;
    logic [BW-1:0]   g, pw;
    g  = find_root();
    pw = 8'h01;
    for (int j = 0; j < BW; j++) begin
      m[8*j +: 8] = pw;
      pw = t_mul(pw, g);
    end
    return m;
  endfunction

  function automatic logic [8*BW-1:0] map_bwd(input logic [8*BW-1:0] fw);
    logic [8*BW-1:0] m;
    m = '0;
    for (int i = 0; i < BW; i++)
      for (int x = 0; x < 256; x++)
        if (mat_apply(fw, 8'(x)) == (8'h01 << i)) m[8*i +: 8] = 8'(x);
    return m;
  endfunction

  function automatic logic [8*BW-1:0] in_map();
    logic [8*BW-1:0] fw, m;
    fw = map_fwd();
    for (int j = 0; j < BW; j++) m[8*j +: 8] = mat_apply(fw, aff_lin(8'h01 << j));
    return m;
  endfunction

  function automatic logic [8*BW-1:0] out_map();
    logic [8*BW-1:0] bw, m;
    bw = map_bwd(map_fwd());
    for (int j = 0; j < BW; j++) m[8*j +: 8] = aff_lin(mat_apply(bw, 8'h01 << j));
    return m;
  endfunction

  // destination share of a cubic cross term, never one of its own indices
  function automatic int inv_dest(input int j, input int k, input int m);
    int st, d;
    logic fnd;
    st  = (j + k + m) % NS_INV;
    d   = 0;
    fnd = 1'b0;
    for (int s = 0; s < NS_INV; s++) begin
      if (!fnd && ((st + s) % NS_INV) != j && ((st + s) % NS_INV) != k &&
          ((st + s) % NS_INV) != m) begin
        d   = (st + s) % NS_INV;
        fnd = 1'b1;
      end
    end
    return d;
  endfunction

  // destination of a 3x5 cross term, never the 3-share index
  function automatic int ub_dest(input int j, input int k);
    return (j + 1 + (k % 2)) % NS_IN;
  endfunction

endpackage

// File: rtl/sm4ti_norm_stage.sv
module sm4ti_norm_stage
  import sm4ti_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         vld_in,
  input  logic [NS_IN-1:0][BW-1:0]     x_sh,
  input  logic [RND_W-1:0]             rnd,
  output logic                         vld_q,
  output logic [NS_INV-1:0][HW-1:0]    d_q,
  output logic [NS_IN-1:0][BW-1:0]     t_q
);

  localparam logic [8*BW-1:0] IN_MAP = in_map();
  localparam logic [BW-1:0]   IN_C   = mat_apply(map_fwd(), AFF_C);

  logic [NS_IN-1:0][BW-1:0]  t_d;
  logic [NS_IN-1:0][HW-1:0]  h, l, z;
  logic [NS_INV-1:0][HW-1:0] d_d;
  logic [BW-1:0]             t_sum;
  logic [HW-1:0]             delta_ref;

  always_comb begin
    for (int s = 0; s < NS_IN; s++) begin
      t_d[s] = mat_apply(IN_MAP, x_sh[s]) ^ ((s == 0) ? IN_C : 8'h00);
      h[s]   = t_d[s][7:4];
      l[s]   = t_d[s][3:0];
    end
    // share i of the norm never touches input share i
    z[0] = gf16_mul(h[1], l[1]) ^ gf16_mul(h[1], l[2]) ^ gf16_mul(h[2], l[1]) ^ sq_scale(h[1], l[1]);
    z[1] = gf16_mul(h[2], l[2]) ^ gf16_mul(h[2], l[0]) ^ gf16_mul(h[0], l[2]) ^ sq_scale(h[2], l[2]);
    z[2] = gf16_mul(h[0], l[0]) ^ gf16_mul(h[0], l[1]) ^ gf16_mul(h[1], l[0]) ^ sq_scale(h[0], l[0]);
    d_d[0] = z[0] ^ rnd[3:0];
    d_d[1] = z[1] ^ rnd[7:4];
    d_d[2] = z[2];
    d_d[3] = rnd[3:0];
    d_d[4] = rnd[7:4];
    t_sum     = t_d[0] ^ t_d[1] ^ t_d[2];
    delta_ref = gf16_mul(t_sum[7:4], t_sum[3:0]) ^ sq_scale(t_sum[7:4], t_sum[3:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      d_q   <= '0;
      t_q   <= '0;
    end else begin
      vld_q <= vld_in;
      if (vld_in) begin
        d_q <= d_d;
        t_q <= t_d;
      end
    end
  end

  // R1: the five norm shares recombine to the norm of the unshared tower value
  a_r1_norm_value: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in |=> ((d_q[0] ^ d_q[1] ^ d_q[2] ^ d_q[3] ^ d_q[4]) == $past(delta_ref)));

endmodule

// File: rtl/sm4ti_inv_stage.sv
module sm4ti_inv_stage
  import sm4ti_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         vld_in,
  input  logic [NS_INV-1:0][HW-1:0]    d_in,
  input  logic [NS_IN-1:0][BW-1:0]     t_in,
  output logic                         vld_q,
  output logic [NS_INV-1:0][HW-1:0]    v_q,
  output logic [NS_IN-1:0][BW-1:0]     t_q
);

  logic [NS_INV-1:0][HW-1:0] p2, p4, p8, v_d;
  logic [2:0]                di;
  logic [HW-1:0]             inv_ref;

  // x^-1 = x^2 * x^4 * x^8 ; each power is linear per share
  always_comb begin
    for (int s = 0; s < NS_INV; s++) begin
      p2[s] = gf16_mul(d_in[s], d_in[s]);
      p4[s] = gf16_mul(p2[s], p2[s]);
      p8[s] = gf16_mul(p4[s], p4[s]);
    end
    v_d = '0;
    di  = '0;
    for (int j = 0; j < NS_INV; j++)
      for (int k = 0; k < NS_INV; k++)
        for (int m = 0; m < NS_INV; m++) begin
          di     = 3'(inv_dest(j, k, m));
          v_d[di] = v_d[di] ^ gf16_mul(gf16_mul(p2[j], p4[k]), p8[m]);
        end
    inv_ref = gf16_inv_ref(d_in[0] ^ d_in[1] ^ d_in[2] ^ d_in[3] ^ d_in[4]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      v_q   <= '0;
      t_q   <= '0;
    end else begin
      vld_q <= vld_in;
      if (vld_in) begin
        v_q <= v_d;
        t_q <= t_in;
      end
    end
  end

  // R8: inverse recombines to x^14, which maps zero to zero
  a_r8_inverse_value: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in |=> ((v_q[0] ^ v_q[1] ^ v_q[2] ^ v_q[3] ^ v_q[4]) == $past(inv_ref)));

endmodule

// File: rtl/sm4ti_out_stage.sv
module sm4ti_out_stage
  import sm4ti_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         vld_in,
  input  logic [NS_INV-1:0][HW-1:0]    v_in,
  input  logic [NS_IN-1:0][BW-1:0]     t_in,
  output logic                         vld_q,
  output logic [NS_IN-1:0][BW-1:0]     o_q
);

  localparam logic [8*BW-1:0] OUT_MAP = out_map();

  logic [NS_IN-1:0][HW-1:0] hp, lp;
  logic [NS_IN-1:0][BW-1:0] o_d;
  logic [1:0]               di;

  always_comb begin
    hp = '0;
    lp = '0;
    di = '0;
    for (int j = 0; j < NS_IN; j++)
      for (int k = 0; k < NS_INV; k++) begin
        di     = 2'(ub_dest(j, k));
        hp[di] = hp[di] ^ gf16_mul(t_in[j][7:4], v_in[k]);
        lp[di] = lp[di] ^ gf16_mul(t_in[j][7:4] ^ t_in[j][3:0], v_in[k]);
      end
    for (int s = 0; s < NS_IN; s++)
      o_d[s] = mat_apply(OUT_MAP, {hp[s], lp[s]}) ^ ((s == 0) ? AFF_C : 8'h00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      o_q   <= '0;
    end else begin
      vld_q <= vld_in;
      if (vld_in) o_q <= o_d;
    end
  end

  // R6: shares hold when no operand reaches this stage
  a_r6_hold_shares: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_in |=> $stable(o_q));

endmodule

// File: rtl/sm4ti_sbox.sv
module sm4ti_sbox
  import sm4ti_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [7:0]    in_sh0,
  input  logic [7:0]    in_sh1,
  input  logic [7:0]    in_sh2,
  input  logic [7:0]    rnd,
  output logic          out_vld,
  output logic [7:0]    out_sh0,
  output logic [7:0]    out_sh1,
  output logic [7:0]    out_sh2
);

  logic [NS_IN-1:0][BW-1:0]  x_sh, t1, t2, o_sh;
  logic [NS_INV-1:0][HW-1:0] d1, v2;
  logic                      vld1, vld2, vld3;

  assign x_sh = {in_sh2, in_sh1, in_sh0};

  sm4ti_norm_stage u_norm (
    .clk(clk), .rst_n(rst_n), .vld_in(in_vld), .x_sh(x_sh), .rnd(rnd),
    .vld_q(vld1), .d_q(d1), .t_q(t1)
  );

  sm4ti_inv_stage u_inv (
    .clk(clk), .rst_n(rst_n), .vld_in(vld1), .d_in(d1), .t_in(t1),
    .vld_q(vld2), .v_q(v2), .t_q(t2)
  );

  sm4ti_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .vld_in(vld2), .v_in(v2), .t_in(t2),
    .vld_q(vld3), .o_q(o_sh)
  );

  assign out_vld = vld3;
  assign out_sh0 = o_sh[0];
  assign out_sh1 = o_sh[1];
  assign out_sh2 = o_sh[2];

  // R2: an accepted operand leaves three edges later
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> ##3 out_vld);

  // R2: no result appears without an operand
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |-> ##3 !out_vld);

  // R7: reset state on the outputs
  a_r7_reset_state: assert property (@(posedge clk)
    !rst_n |-> (!out_vld && out_sh0 == 8'h00 && out_sh1 == 8'h00 && out_sh2 == 8'h00));

endmodule

// File: tb/test_sm4ti_sbox.sv
module test_sm4ti_sbox;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_vld;
  logic [7:0] in_sh0, in_sh1, in_sh2, rnd;
  logic       out_vld;
  logic [7:0] out_sh0, out_sh1, out_sh2;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic       hv [3];
  logic [7:0] hx [3];
  string      htag [3];
  logic [23:0] prev_sh;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm4ti_sbox i_sm4ti_sbox (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .in_sh0(in_sh0), .in_sh1(in_sh1), .in_sh2(in_sh2), .rnd(rnd),
    .out_vld(out_vld), .out_sh0(out_sh0), .out_sh1(out_sh1), .out_sh2(out_sh2)
  );

  // ---------------- reference model in GF(2^8), polynomial basis ----------
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, sh;
    acc = 0; sh = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'hF5 : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] ref_inv(input logic [7:0] x);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < 254; i++) r = ref_mul(r, x);
    return r;
  endfunction

  function automatic logic [7:0] ref_aff(input logic [7:0] x);
    logic [7:0] rows [8];
    logic [7:0] y;
    rows = '{8'hA7, 8'h4F, 8'h9E, 8'h3D, 8'h7A, 8'hF4, 8'hE9, 8'hD3};
    for (int i = 0; i < 8; i++) y[i] = ^(rows[i] & x);
    return y ^ 8'hD3;
  endfunction

  function automatic logic [7:0] sbox_ref(input logic [7:0] x);
    return ref_aff(ref_inv(ref_aff(x)));
  endfunction

  // ---------------- checking ----------------------------------------------
  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] x, input logic [7:0] s1,
                      input logic [7:0] s2, input logic [7:0] r, input string tag);
    logic [7:0] rec;
    @(negedge clk);
    rec = out_sh0 ^ out_sh1 ^ out_sh2;
    if (hv[2]) begin
      chk(out_vld == 1'b1, "R2", "out_vld after operand", 32'(out_vld), 32'd1);
      chk(rec == sbox_ref(hx[2]), htag[2], $sformatf("S(%02h)", hx[2]),
          32'(rec), 32'(sbox_ref(hx[2])));
    end else begin
      chk(out_vld == 1'b0, "R2", "out_vld without operand", 32'(out_vld), 32'd0);
      chk({out_sh0, out_sh1, out_sh2} == prev_sh, "R6", "shares held",
          32'({out_sh0, out_sh1, out_sh2}), 32'(prev_sh));
    end
    prev_sh = {out_sh0, out_sh1, out_sh2};
    hv[2] = hv[1]; hx[2] = hx[1]; htag[2] = htag[1];
    hv[1] = hv[0]; hx[1] = hx[0]; htag[1] = htag[0];
    hv[0] = v;     hx[0] = x;     htag[0] = tag;
    in_vld = v;
    in_sh1 = s1;
    in_sh2 = s2;
    in_sh0 = x ^ s1 ^ s2;
    rnd    = r;
  endtask

  task automatic push_rand(input logic [7:0] x, input string tag);
    step(1'b1, x, 8'($urandom), 8'($urandom), 8'($urandom), tag);
  endtask

  task automatic idle();
    step(1'b0, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "R6");
  endtask

  // ---------------- watchdog ----------------------------------------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------------------------------------
  initial begin
    int seed_init;
    seed_init = $urandom(32'h51B0C4);
    for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; hx[i] = 8'h00; htag[i] = "R1"; end
    prev_sh = 24'h0;
    rst_n  = 1'b0;
    in_vld = 1'b0;
    in_sh0 = 8'h00; in_sh1 = 8'h00; in_sh2 = 8'h00; rnd = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_vld == 1'b0, "R7", "out_vld in reset", 32'(out_vld), 32'd0);
    chk({out_sh0, out_sh1, out_sh2} == 24'h0, "R7", "shares in reset",
        32'({out_sh0, out_sh1, out_sh2}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld == 1'b0, "R7", "out_vld after reset", 32'(out_vld), 32'd0);
    chk({out_sh0, out_sh1, out_sh2} == 24'h0, "R7", "shares after reset",
        32'({out_sh0, out_sh1, out_sh2}), 32'd0);

    // R8: known answers of the reference itself, and zero through the design
    chk(sbox_ref(8'h00) == 8'hD6, "R8", "reference S(00)", 32'(sbox_ref(8'h00)), 32'hD6);
    chk(sbox_ref(8'h01) == 8'h90, "R8", "reference S(01)", 32'(sbox_ref(8'h01)), 32'h90);
    chk(sbox_ref(8'hFF) == 8'h48, "R8", "reference S(FF)", 32'(sbox_ref(8'hFF)), 32'h48);
    step(1'b1, 8'h00, 8'h00, 8'h00, 8'h00, "R8");
    step(1'b1, 8'h00, 8'hA5, 8'h3C, 8'hFF, "R8");
    step(1'b1, 8'h01, 8'h00, 8'h00, 8'h00, "R8");
    step(1'b1, 8'hFF, 8'h12, 8'h34, 8'h56, "R8");

    // R2: isolated operand, then gaps
    idle(); idle(); idle();
    push_rand(8'h6B, "R2");
    idle(); idle(); idle(); idle();

    // R1, R5: every byte, back to back
    for (int x = 0; x < 256; x++) push_rand(8'(x), (x % 2 == 0) ? "R1" : "R5");

    // R3: one byte, many splits, fixed random bits
    for (int i = 0; i < 16; i++) step(1'b1, 8'h5A, 8'($urandom), 8'($urandom), 8'h3E, "R3");

    // R4: one byte, one split, many random values
    for (int i = 0; i < 16; i++) step(1'b1, 8'hC7, 8'h81, 8'h2F, 8'($urandom), "R4");

    // R6 with R1: random gaps, garbage on idle inputs
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 9) < 7) push_rand(8'($urandom), "R1");
      else idle();
    end

    for (int i = 0; i < 5; i++) idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule